// File: doc/BRIEF.md
# Multicore Reset and Power-Up Control Registers

This block is a word-addressed register file that governs reset and start-up for a two-core processing cluster. A host issues single-cycle accesses inside a 4 KB window. The word index is the byte address divided by four. A read returns registered data on the following cycle. A write updates the selected register at the clock edge that samples it.

Most registers only hold values. Two of them act on the cores. In the core-reset register, a write that flips a core's reset bit sends that core a one-cycle reset request. The bit then stays as written until the core reports completion, and is cleared at that point. In the core-power register, a write that flips the secondary core's enable bit sends either a power-on request or a power-off request. A power-on request carries an entry address and an argument, both taken from general-purpose registers. In both cases the secondary core's reset bit is cleared once that core reports completion.

The processor models, boot firmware and clocking lie outside the block. They appear here only as request pulses and per-core done inputs.

Top module: `core_reset_ctrl`

## Requirements
- R1: After reset, word 0 (system control) reads 0x000000A0, word 11 (reset status) reads 0x00000001, word 13 (interrupt mask) reads 0x0000001F, and every other word from 0 to 23 reads 0.
- R2: A read strobe at byte address 4*k returns the contents of word k on bus_rdata, with bus_rvalid high, in the cycle after the strobe.
- R3: An aligned access to word 24 or above (up to 1023) raises bus_err in the cycle after the strobe. Such a read returns 0, and such a write changes no register.
- R4: An access whose two low address bits are not both zero raises bus_err and is discarded. A write of this kind leaves the word at the aligned address unchanged.
- R5: Words other than 1 and 2 store the full written value, and writing them raises no request output.
- R6: A write to word 1 (core reset) that changes bit 0 or bit 1 pulses core_rst_req[0] or core_rst_req[1] for exactly the cycle after the write. Bits that do not change raise no pulse.
- R7: After a core reset request, word 1 bit c keeps its written value until core_done[c] is sampled, and is cleared at that edge. core_done[c] has no effect while no request for core c is pending.
- R8: A write to word 2 (core power) that changes bit 1 from 0 to 1 pulses c1_on_req in the next cycle. In that cycle c1_entry equals word 16 (general-purpose 3), c1_arg equals word 17 (general-purpose 4), and c1_level is 3. A change of bit 1 from 1 to 0 pulses c1_off_req instead. Changes to other bits of word 2 raise no request.
- R9: After a power-on or power-off request, word 1 bit 1 is cleared when core_done[1] is sampled.
- R10: A further change of a core's reset bit while that core's request is still pending issues another request pulse.
- R11: A write to word 1 stores every written bit, including the bits that have no action attached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response, the cycle after a read strobe |
| bus_err | output | 1 | Bad access flag, the cycle after the strobe |
| core_rst_req | output | 2 | Per-core reset request pulse |
| core_done | input | 2 | Per-core completion report |
| c1_on_req | output | 1 | Secondary core power-on request pulse |
| c1_off_req | output | 1 | Secondary core power-off request pulse |
| c1_entry | output | 32 | Start address sent with the power-on request |
| c1_arg | output | 32 | Context argument sent with the power-on request |
| c1_level | output | 2 | Privilege level for start-up (3) |

## Verification
The hardest state to reach from the ports is a request that is still pending when a second change arrives. The core's done input must be held back while the same reset bit is flipped again, or while the power bit is flipped after a reset request. The directed tasks therefore issue two or three writes before any done pulse. They then check that each write produced its own pulse, that the reset bit stayed as written through all of them, and that a single done pulse cleared it. A done pulse sent to a core with nothing pending is read back through word 1, to show that it changed nothing.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  localparam int NUM_CORES = 2;

  // Word indices; the order fixes the address map
  localparam int IDX_SCR   = 0;
  localparam int IDX_CRST  = 1;
  localparam int IDX_CPWR  = 2;
  localparam int IDX_AUX   = 3;
  localparam int IDX_EXT   = 4;
  localparam int IDX_PHY0  = 5;
  localparam int NUM_PHY   = 4;
  localparam int IDX_BOOT0 = IDX_PHY0 + NUM_PHY;
  localparam int IDX_BOOT1 = IDX_BOOT0 + 1;
  localparam int IDX_RSTAT = IDX_BOOT1 + 1;
  localparam int IDX_ISTAT = IDX_RSTAT + 1;
  localparam int IDX_IMASK = IDX_ISTAT + 1;
  localparam int IDX_GP1   = IDX_IMASK + 1;

  // Bit positions with actions attached
  localparam int BIT_C0_RST = 0;
  localparam int BIT_C1_RST = 1;
  localparam int BIT_C1_EN  = 1;

  // Byte address to word number
  function automatic logic [31:0] word_of(input logic [31:0] byte_addr);
    return byte_addr >> 2;
  endfunction

  // A word number lies inside the implemented set
  function automatic logic word_present(input logic [31:0] word, input int unsigned count);
    return word < count;
  endfunction

  // Value a word takes at reset
  function automatic logic [31:0] reset_word(input int idx, input logic [31:0] scr_v,
                                             input logic [31:0] rstat_v,
                                             input logic [31:0] imask_v);
    if (idx == IDX_SCR)   return scr_v;
    if (idx == IDX_RSTAT) return rstat_v;
    if (idx == IDX_IMASK) return imask_v;
    return 32'h0;
  endfunction

  // Bits that a write flips relative to the stored value
  function automatic logic [31:0] flipped(input logic [31:0] old_v, input logic [31:0] new_v);
    return old_v ^ new_v;
  endfunction

endpackage

// File: rtl/rstc_decode.sv
module rstc_decode #(
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 24,
  parameter int IDX_W    = 5
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              wr_en,
  output logic              rd_en,
  output logic              acc_err,
  output logic [IDX_W-1:0]  idx
);
  import rstc_pkg::*;

  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              misaligned;
  logic              in_range;
  logic              good;

  assign widx       = bus_addr[ADDR_W-1:2];
  assign misaligned = |bus_addr[1:0];
  assign in_range   = word_present(word_of(32'({bus_addr})), NUM_REGS);
  assign good       = bus_sel && !misaligned && in_range;

  assign wr_en   = good && bus_wr;
  assign rd_en   = good && !bus_wr;
  assign acc_err = bus_sel && !good;
  assign idx     = widx[IDX_W-1:0];

endmodule

// File: rtl/rstc_regfile.sv
module rstc_regfile #(
  parameter int          DATA_W    = 32,
  parameter int          NUM_REGS  = 24,
  parameter int          IDX_W     = 5,
  parameter logic [31:0] SCR_INIT  = 32'h0000_00A0,
  parameter logic [31:0] RSTAT_INIT = 32'h0000_0001,
  parameter logic [31:0] IMASK_INIT = 32'h0000_001F
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic                           rd_any,
  input  logic                           acc_err,
  input  logic [IDX_W-1:0]               idx,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [rstc_pkg::NUM_CORES-1:0] clr_mask,
  output logic [DATA_W-1:0]              rdata,
  output logic                           rvalid,
  output logic                           err,
  output logic [DATA_W-1:0]              crst_q,
  output logic [DATA_W-1:0]              cpwr_q,
  output logic [DATA_W-1:0]              gp3_q,
  output logic [DATA_W-1:0]              gp4_q
);
  import rstc_pkg::*;

  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    logic [DATA_W-1:0] q;
    logic              hit;
    assign hit = wr_en && (idx == IDX_W'(i));

    if (i == IDX_CRST) begin : g_crst
      logic [DATA_W-1:0] nxt;
      always_comb begin
        nxt = hit ? wdata : q;
        nxt = nxt & ~{{(DATA_W-NUM_CORES){1'b0}}, clr_mask};
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= DATA_W'(reset_word(i, SCR_INIT, RSTAT_INIT, IMASK_INIT));
        else        q <= nxt;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= DATA_W'(reset_word(i, SCR_INIT, RSTAT_INIT, IMASK_INIT));
        else if (hit) q <= wdata;
      end
    end

    assign regs_q[i] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      err    <= 1'b0;
    end else begin
      rvalid <= rd_any;
      err    <= acc_err;
      if (rd_en)       rdata <= regs_q[idx];
      else if (rd_any) rdata <= '0;
    end
  end

  assign crst_q = regs_q[IDX_CRST];
  assign cpwr_q = regs_q[IDX_CPWR];
  assign gp3_q  = regs_q[IDX_GP1 + 2];
  assign gp4_q  = regs_q[IDX_GP1 + 3];

endmodule

// File: rtl/rstc_core_seq.sv
module rstc_core_seq #(
  parameter int         DATA_W   = 32,
  parameter int         IDX_W    = 5,
  parameter logic [1:0] START_LVL = 2'd3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               idx,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [DATA_W-1:0]              crst_q,
  input  logic [DATA_W-1:0]              cpwr_q,
  input  logic [DATA_W-1:0]              gp3_q,
  input  logic [DATA_W-1:0]              gp4_q,
  input  logic [rstc_pkg::NUM_CORES-1:0] core_done,
  output logic [rstc_pkg::NUM_CORES-1:0] core_rst_req,
  output logic                           c1_on_req,
  output logic                           c1_off_req,
  output logic [DATA_W-1:0]              c1_entry,
  output logic [DATA_W-1:0]              c1_arg,
  output logic [1:0]                     c1_level,
  output logic [rstc_pkg::NUM_CORES-1:0] rst_change,
  output logic                           pwr_change,
  output logic [rstc_pkg::NUM_CORES-1:0] done_clear,
  output logic [rstc_pkg::NUM_CORES-1:0] pending
);
  import rstc_pkg::*;

  logic [31:0]          crst_flip;
  logic [31:0]          cpwr_flip;
  logic                 crst_hit;
  logic                 cpwr_hit;
  logic [NUM_CORES-1:0] trig;

  assign crst_hit  = wr_en && (idx == IDX_W'(IDX_CRST));
  assign cpwr_hit  = wr_en && (idx == IDX_W'(IDX_CPWR));
  assign crst_flip = flipped(32'(crst_q), 32'(wdata));
  assign cpwr_flip = flipped(32'(cpwr_q), 32'(wdata));

  assign rst_change[0] = crst_hit && crst_flip[BIT_C0_RST];
  assign rst_change[1] = crst_hit && crst_flip[BIT_C1_RST];
  assign pwr_change    = cpwr_hit && cpwr_flip[BIT_C1_EN];

  assign trig[0] = rst_change[0];
  assign trig[1] = rst_change[1] || pwr_change;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign done_clear[c] = pending[c] && core_done[c] && !trig[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pending[c]      <= 1'b0;
        core_rst_req[c] <= 1'b0;
      end else begin
        pending[c]      <= trig[c] || (pending[c] && !done_clear[c]);
        core_rst_req[c] <= rst_change[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1_on_req  <= 1'b0;
      c1_off_req <= 1'b0;
      c1_entry   <= '0;
      c1_arg     <= '0;
      c1_level   <= '0;
    end else begin
      c1_on_req  <= pwr_change && wdata[BIT_C1_EN];
      c1_off_req <= pwr_change && !wdata[BIT_C1_EN];
      if (pwr_change && wdata[BIT_C1_EN]) begin
        c1_entry <= gp3_q;
        c1_arg   <= gp4_q;
        c1_level <= START_LVL;
      end
    end
  end

endmodule

// File: rtl/core_reset_ctrl.sv
module core_reset_ctrl #(
  parameter int          ADDR_W     = 12,
  parameter int          DATA_W     = 32,
  parameter int          NUM_GP     = 10,
  parameter logic [31:0] SCR_INIT   = 32'h0000_00A0,
  parameter logic [31:0] RSTAT_INIT = 32'h0000_0001,
  parameter logic [31:0] IMASK_INIT = 32'h0000_001F,
  parameter logic [1:0]  START_LVL  = 2'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err,
  output logic [1:0]        core_rst_req,
  input  logic [1:0]        core_done,
  output logic              c1_on_req,
  output logic              c1_off_req,
  output logic [DATA_W-1:0] c1_entry,
  output logic [DATA_W-1:0] c1_arg,
  output logic [1:0]        c1_level
);
  import rstc_pkg::*;

  localparam int NUM_REGS = IDX_GP1 + NUM_GP;
  localparam int IDX_W    = $clog2(NUM_REGS);

  logic              wr_en;
  logic              rd_en;
  logic              rd_any;
  logic              acc_err;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] crst_q;
  logic [DATA_W-1:0] cpwr_q;
  logic [DATA_W-1:0] gp3_q;
  logic [DATA_W-1:0] gp4_q;
  logic [1:0]        rst_change;
  logic              pwr_change;
  logic [1:0]        done_clear;
  logic [1:0]        pending;

  assign rd_any = bus_sel && !bus_wr;

  rstc_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
  ) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .wr_en(wr_en), .rd_en(rd_en), .acc_err(acc_err), .idx(idx)
  );

  rstc_regfile #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W),
    .SCR_INIT(SCR_INIT), .RSTAT_INIT(RSTAT_INIT), .IMASK_INIT(IMASK_INIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rd_any(rd_any),
    .acc_err(acc_err), .idx(idx), .wdata(bus_wdata), .clr_mask(done_clear),
    .rdata(bus_rdata), .rvalid(bus_rvalid), .err(bus_err),
    .crst_q(crst_q), .cpwr_q(cpwr_q), .gp3_q(gp3_q), .gp4_q(gp4_q)
  );

  rstc_core_seq #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .START_LVL(START_LVL)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx), .wdata(bus_wdata),
    .crst_q(crst_q), .cpwr_q(cpwr_q), .gp3_q(gp3_q), .gp4_q(gp4_q),
    .core_done(core_done), .core_rst_req(core_rst_req),
    .c1_on_req(c1_on_req), .c1_off_req(c1_off_req),
    .c1_entry(c1_entry), .c1_arg(c1_arg), .c1_level(c1_level),
    .rst_change(rst_change), .pwr_change(pwr_change),
    .done_clear(done_clear), .pending(pending)
  );

endmodule

// File: rtl/rstc_checker.sv
module rstc_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic              bus_err,
  input logic [1:0]        core_rst_req,
  input logic [1:0]        core_done,
  input logic              c1_on_req,
  input logic              c1_off_req,
  input logic [1:0]        pending
);
  localparam logic [ADDR_W-1:0] CRST_ADDR = ADDR_W'(rstc_pkg::IDX_CRST * 4);
  localparam logic [ADDR_W-1:0] CPWR_ADDR = ADDR_W'(rstc_pkg::IDX_CPWR * 4);

  p_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid);

  p_bad_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && bus_err) |-> (bus_rdata == '0));

  p_on_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    c1_on_req |-> $past(bus_sel && bus_wr && bus_addr == CPWR_ADDR && bus_wdata[1]));

  p_on_off_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(c1_on_req && c1_off_req));

  for (genvar c = 0; c < 2; c++) begin : g_core
    p_req_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst_req[c] |-> $past(bus_sel && bus_wr && bus_addr == CRST_ADDR));

    p_req_pends_r10: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst_req[c] |-> pending[c]);

    p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pending[c] && !core_done[c]) |=> pending[c]);
  end

endmodule

bind core_reset_ctrl rstc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_rvalid(bus_rvalid), .bus_err(bus_err), .core_rst_req(core_rst_req),
  .core_done(core_done), .c1_on_req(c1_on_req), .c1_off_req(c1_off_req),
  .pending(pending)
);

// File: tb/sim_core_reset_ctrl.sv
module sim_core_reset_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        bus_err;
  logic [1:0]  core_rst_req;
  logic [1:0]  core_done = '0;
  logic        c1_on_req;
  logic        c1_off_req;
  logic [31:0] c1_entry;
  logic [31:0] c1_arg;
  logic [1:0]  c1_level;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  core_reset_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .bus_err(bus_err), .core_rst_req(core_rst_req),
    .core_done(core_done), .c1_on_req(c1_on_req), .c1_off_req(c1_off_req),
    .c1_entry(c1_entry), .c1_arg(c1_arg), .c1_level(c1_level)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
    e = bus_err;
    chk("R2", "rvalid after read", 32'(bus_rvalid), 32'd1);
  endtask

  task automatic done(input int c);
    @(negedge clk);
    core_done[c] = 1'b1;
    @(negedge clk);
    core_done = '0;
  endtask

  task automatic quiet(input string req);
    chk(req, "core_rst_req", 32'(core_rst_req), 32'd0);
    chk(req, "c1_on_req", 32'(c1_on_req), 32'd0);
    chk(req, "c1_off_req", 32'(c1_off_req), 32'd0);
  endtask

  // R1 and R2: reset contents of every implemented word
  task automatic t_reset();
    logic [31:0] d; logic e; logic [31:0] exp;
    for (int k = 0; k < 24; k++) begin
      rd(12'(k * 4), d, e);
      exp = (k == 0) ? 32'hA0 : (k == 11) ? 32'h1 : (k == 13) ? 32'h1F : 32'h0;
      chk("R1", $sformatf("reset word %0d", k), d, exp);
      chk("R2", "no error on valid read", 32'(e), 32'd0);
    end
  endtask

  // R5: plain words store values, no requests
  task automatic t_plain();
    logic [31:0] d; logic e;
    wr(12'h000, 32'hDEAD_0001); quiet("R5");
    wr(12'h014, 32'h0000_5A5A); quiet("R5");
    wr(12'h05C, 32'hCAFE_F00D); quiet("R5");
    rd(12'h000, d, e); chk("R5", "word 0", d, 32'hDEAD_0001);
    rd(12'h014, d, e); chk("R5", "word 5", d, 32'h0000_5A5A);
    rd(12'h05C, d, e); chk("R5", "word 23", d, 32'hCAFE_F00D);
  endtask

  // R3 and R4: bad accesses
  task automatic t_bad();
    logic [31:0] d; logic e;
    rd(12'h060, d, e);
    chk("R3", "read word 24 data", d, 32'h0); chk("R3", "read word 24 err", 32'(e), 32'd1);
    rd(12'hFFC, d, e);
    chk("R3", "read word 1023 data", d, 32'h0); chk("R3", "read word 1023 err", 32'(e), 32'd1);
    wr(12'h080, 32'h1111_1111);
    chk("R3", "write word 32 err", 32'(bus_err), 32'd1);
    rd(12'h000, d, e); chk("R3", "word 0 untouched", d, 32'hDEAD_0001);
    wr(12'h039, 32'h7777_7777);
    chk("R4", "misaligned write err", 32'(bus_err), 32'd1);
    rd(12'h038, d, e); chk("R4", "word 14 untouched", d, 32'h0);
    rd(12'h016, d, e);
    chk("R4", "misaligned read data", d, 32'h0); chk("R4", "misaligned read err", 32'(e), 32'd1);
  endtask

  // R6, R7, R11: core 0 reset and its done handshake
  task automatic t_core_reset();
    logic [31:0] d; logic e;
    wr(12'h004, 32'h0000_F001);
    chk("R6", "pulse core0 only", 32'(core_rst_req), 32'd1);
    @(negedge clk);
    chk("R6", "pulse one cycle", 32'(core_rst_req), 32'd0);
    rd(12'h004, d, e); chk("R11", "full value stored", d, 32'h0000_F001);
    done(1);
    rd(12'h004, d, e); chk("R7", "stray done ignored", d, 32'h0000_F001);
    done(0);
    rd(12'h004, d, e); chk("R7", "bit0 cleared by done", d, 32'h0000_F000);
    wr(12'h004, 32'h0000_0F00);
    chk("R6", "upper bit changes no pulse", 32'(core_rst_req), 32'd0);
  endtask

  // R10: repeated changes while pending
  task automatic t_reissue();
    logic [31:0] d; logic e;
    wr(12'h004, 32'h0000_0F02);
    chk("R10", "first pulse core1", 32'(core_rst_req), 32'd2);
    wr(12'h004, 32'h0000_0F00);
    chk("R10", "second pulse core1", 32'(core_rst_req), 32'd2);
    wr(12'h004, 32'h0000_0F02);
    chk("R10", "third pulse core1", 32'(core_rst_req), 32'd2);
    rd(12'h004, d, e); chk("R7", "bit1 held while pending", d, 32'h0000_0F02);
    done(1);
    rd(12'h004, d, e); chk("R7", "bit1 cleared by done", d, 32'h0000_0F00);
  endtask

  // R8 and R9: power on and off of core 1
  task automatic t_power();
    logic [31:0] d; logic e;
    wr(12'h040, 32'h8000_0100);
    wr(12'h044, 32'h0000_1234);
    wr(12'h004, 32'h0000_0F02);
    wr(12'h008, 32'h0000_0002);
    chk("R8", "on pulse", 32'(c1_on_req), 32'd1);
    chk("R8", "no off pulse", 32'(c1_off_req), 32'd0);
    chk("R8", "no reset pulse", 32'(core_rst_req), 32'd0);
    chk("R8", "entry from GP3", c1_entry, 32'h8000_0100);
    chk("R8", "arg from GP4", c1_arg, 32'h0000_1234);
    chk("R8", "level", 32'(c1_level), 32'd3);
    @(negedge clk);
    chk("R8", "on pulse one cycle", 32'(c1_on_req), 32'd0);
    rd(12'h004, d, e); chk("R9", "bit1 held before done", d, 32'h0000_0F02);
    done(1);
    rd(12'h004, d, e); chk("R9", "bit1 cleared after on", d, 32'h0000_0F00);
    wr(12'h008, 32'h0000_0000);
    chk("R8", "off pulse", 32'(c1_off_req), 32'd1);
    chk("R8", "no on pulse", 32'(c1_on_req), 32'd0);
    wr(12'h008, 32'h0000_0001);
    quiet("R8");
    done(1);
    rd(12'h008, d, e); chk("R8", "power word stored", d, 32'h0000_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "rvalid idle", 32'(bus_rvalid), 32'd0);
    quiet("R1");
    t_reset();
    t_plain();
    t_bad();
    t_core_reset();
    t_reissue();
    t_power();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 50000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired (all R): actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule